// File: doc/BRIEF.md
# Trigger Period Measurement Counter

This block learns the period of a repetitive input signal. It counts system clock cycles between two successive trigger edges taken from a comparator output. A start command arms it. The comparator output is synchronized, and its rising edges are used as trigger events. The first rising edge after start opens the measurement and the next rising edge closes it. The number of clock cycles between the two edges is reported as the learned period, together with a one-cycle done strobe. Later timing calculations use that period to place sample instants.

The block must not stall the acquisition loop. The slowest signal that can be handled depends on the virtual sample rate in use, so the timeout limit is a runtime input. It is latched on each start command. If the second edge does not arrive within that limit, the block still finishes. It raises a timeout flag and reports the limit itself as the period, which stands for a very low frequency signal. The display therefore keeps refreshing even when there is no usable trigger. If no edge arrives at all after start, the block times out the same way.

Top module: `trig_period_meter`

## Requirements
- R1: After reset, period_out is 0 and done and timeout are both low.
- R2: period_out equals the number of clock cycles between the first and the second rising edge of cmp_in that follow start, and it comes with done high and timeout low.
- R3: Falling edges of cmp_in have no effect, so the reported period does not depend on the duty cycle of the input.
- R4: done is high for exactly one clock cycle for each measurement.
- R5: If no second rising edge arrives within limit cycles of the first one, the block finishes with timeout high and period_out equal to limit.
- R6: If no rising edge arrives at all after start, done rises exactly limit+1 cycles after the cycle in which start was sampled. timeout is then high and period_out equals limit.
- R7: A period exactly equal to limit is a valid measurement (timeout low). A period of limit+1 produces a timeout.
- R8: limit is captured when start is sampled. Changing it during a measurement has no effect on that measurement.
- R9: After done, further edges are ignored. period_out and timeout hold their values until the next start, and a start clears timeout.
- R10: A start during a measurement discards it and restarts the measurement from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a new measurement (single-cycle command) |
| cmp_in | input | 1 | Asynchronous comparator output |
| limit | input | CNT_W | Timeout limit in clock cycles, latched on start |
| period_out | output | CNT_W | Learned period, or limit after a timeout |
| done | output | 1 | One-cycle strobe when a measurement finishes |
| timeout | output | 1 | Set when the last measurement timed out |

## Verification
A table of square waves drives the counter. The waves have different periods and different high times, so a design that counts between a rising and a falling edge reports the wrong value. The table includes a period exactly at the limit and one cycle above it, which separates a less-than from a less-or-equal comparison. Separate directed runs cover three further cases. In the first, no edge arrives at all, and the cycle-exact latency to done is checked. In the second, the limit is changed while a measurement is running. In the third, start is given again mid-measurement and the input keeps toggling after done.

// File: rtl/trig_period_meter.sv
module trig_period_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] period_out,
  output logic             done,
  output logic             timeout
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} st_t;

  st_t              st;
  logic [2:0]       sync;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;
  logic             rise;
  logic             expired;

  assign rise    = sync[1] & ~sync[2];
  assign expired = cnt >= lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cmp_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      lim_q      <= '0;
      period_out <= '0;
      done       <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st      <= S_ARM;
        cnt     <= '0;
        lim_q   <= limit;
        timeout <= 1'b0;
      end else begin
        case (st)
          S_ARM: begin
            if (rise) begin
              st  <= S_RUN;
              cnt <= CNT_W'(1);
            end else if (expired) begin
              st         <= S_IDLE;
              period_out <= lim_q;
              timeout    <= 1'b1;
              done       <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RUN: begin
            if (rise) begin
              st         <= S_IDLE;
              period_out <= cnt;
              done       <= 1'b1;
            end else if (expired) begin
              st         <= S_IDLE;
              period_out <= lim_q;
              timeout    <= 1'b1;
              done       <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  a_r5_timeout_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (done && period_out == lim_q));

  // R9
  a_r9_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (period_out != $past(period_out)) |-> done);

  // R9
  a_r9_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(start));

  // R7
  a_r7_valid_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timeout) |-> (period_out <= lim_q && period_out != '0));

endmodule

// File: tb/trig_period_meter_test.sv
module trig_period_meter_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_in = 1'b0;
  logic [W-1:0] limit = '0;
  logic [W-1:0] period_out;
  logic         done;
  logic         timeout;

  int checks = 0;
  int errors = 0;
  int got_c;
  logic [W-1:0] got_p;
  logic got_t;

  always #10 clk = ~clk;

  trig_period_meter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .limit(limit), .period_out(period_out), .done(done), .timeout(timeout)
  );

  // period, high time, limit
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{10, 5, 40}, '{17, 2, 40}, '{23, 20, 60}, '{2, 1, 30},
    '{40, 8, 40}, '{41, 8, 40}, '{120, 60, 50}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(int lim);
    @(negedge clk);
    limit = W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wave(int p, int hi, int lead);
    repeat (lead) @(negedge clk);
    forever begin
      cmp_in = 1'b1;
      repeat (hi) @(negedge clk);
      cmp_in = 1'b0;
      repeat (p - hi) @(negedge clk);
    end
  endtask

  task automatic wait_done(int bound);
    got_c = 0;
    while (!done && got_c < bound) begin
      @(negedge clk);
      got_c++;
    end
    got_p = period_out;
    got_t = timeout;
  endtask

  task automatic measure(int p, int hi, int lim);
    pulse_start(lim);
    fork
      wave(p, hi, 3);
      wait_done(2 * lim + 3 * p + 20);
    join_any
    disable fork;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 period", int'(period_out), 0);
    check("R1 done", int'(done), 0);
    check("R1 timeout", int'(timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      measure(VEC[i][0], VEC[i][1], VEC[i][2]);
      cmp_in = 1'b0;
      if (VEC[i][0] <= VEC[i][2]) begin
        check("R2 R3 R7 period", int'(got_p), VEC[i][0]);
        check("R2 R7 timeout", int'(got_t), 0);
      end else begin
        check("R5 R7 period", int'(got_p), VEC[i][2]);
        check("R5 R7 timeout", int'(got_t), 1);
      end
      @(negedge clk);
      check("R4 done width", int'(done), 0);
      repeat (4) @(negedge clk);
    end

    // R6: no edge at all
    cmp_in = 1'b0;
    pulse_start(25);
    wait_done(200);
    check("R6 latency", got_c, 26);
    check("R6 period", int'(got_p), 25);
    check("R6 timeout", int'(got_t), 1);

    // R9: start clears timeout
    pulse_start(30);
    check("R9 timeout cleared", int'(timeout), 0);
    check("R9 period held", int'(period_out), 25);
    fork wave(12, 6, 3); wait_done(200); join_any
    disable fork;
    check("R9 new period", int'(got_p), 12);
    // R9: edges after done ignored
    fork wave(7, 3, 1); join_none
    repeat (40) @(negedge clk);
    disable fork;
    cmp_in = 1'b0;
    check("R9 period stable", int'(period_out), 12);
    check("R9 timeout stable", int'(timeout), 0);
    check("R9 no extra done", int'(done), 0);

    // R8: limit change mid measurement
    repeat (4) @(negedge clk);
    pulse_start(30);
    limit = W'(5);
    fork wave(20, 10, 3); wait_done(200); join_any
    disable fork;
    cmp_in = 1'b0;
    check("R8 period", int'(got_p), 20);
    check("R8 timeout", int'(got_t), 0);

    // R10: restart mid measurement
    repeat (4) @(negedge clk);
    pulse_start(60);
    repeat (2) @(negedge clk);
    cmp_in = 1'b1;
    repeat (4) @(negedge clk);
    cmp_in = 1'b0;
    pulse_start(60);
    fork wave(15, 7, 3); wait_done(300); join_any
    disable fork;
    cmp_in = 1'b0;
    check("R10 period", int'(got_p), 15);
    check("R10 timeout", int'(got_t), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule